// File: doc/BRIEF.md
# Forbidden-Pattern-Free Bus Codec

This block is a combinational encoder and decoder for a wide on-chip parallel bus whose wires couple strongly to their neighbours. A data word is widened into a codeword in which no three neighbouring wires ever hold 010 or 101. Those two patterns are what make a middle wire see the worst coupling when the bus switches. The decoder at the far end restores the original word exactly.

The data word is cut into 4-bit nibbles. Each nibble is coded on its own into one of the 16 five-bit words that contain neither pattern. Three junction wires sit between each pair of neighbouring groups. They repeat the edge bits of the two groups, so no forbidden pattern can form across a boundary. For G nibbles the bus is 8G-3 wires wide, so an 8-bit word needs 13 wires.

The codec keeps no state. Each output is a pure function of the current input. The encode and decode paths share one top module and are used independently: the encoder drives the wires at the sender, and the decoder reads them at the receiver.

Top module: `fpf_bus_codec`

## Requirements
- R1: No three adjacent bits of `enc_bus` ever equal 010 or 101, for any value of `enc_data`.
- R2: Nibble g (`enc_data[4g+3:4g]`) with value k drives `enc_bus[8g+4:8g]`. That field carries the k-th smallest (counting from 0) five-bit value free of 010 and 101, with bit 0 on the lowest wire. The code order is 00,01,03,06,07,0C,0E,0F,10,11,13,18,19,1C,1E,1F hex.
- R3: For each boundary after group g (g < G-1), wires 8g+5 and 8g+6 equal wire 8g+4. Wire 8g+7 equals wire 8g+8.
- R4: The coded bus is 8·(DATA_W/4)-3 wires wide: 29 wires for the default DATA_W of 16, and 13 wires for DATA_W of 8.
- R5: The encoder is memoryless. The same `enc_data` always yields the same `enc_bus`, whatever values came before.
- R6: Decoding recovers the data exactly: with `dec_bus` equal to the encoder output for x, `dec_data` equals x for every one of the 2^DATA_W values.
- R7: The decoder ignores the junction wires. Any values on wires 8g+5..8g+7 leave `dec_data` unchanged.
- R8: A 5-bit group field of `dec_bus` that is not one of the 16 code words decodes to nibble 0. The other nibbles are not affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data | input | DATA_W | Data word to be coded |
| enc_bus | output | 8·DATA_W/4-3 | Coded wires driven onto the bus |
| dec_bus | input | 8·DATA_W/4-3 | Coded wires as received |
| dec_data | output | DATA_W | Recovered data word |

## Verification
The hardest condition to reach from the ports is a received bus that the encoder can never produce. That includes junction wires that disagree with their neighbouring groups, and group fields that are not code words. The bench reaches it by opening the loop from `enc_bus` to `dec_bus`. It drives the decoder with encoder output whose junction bits are overwritten at random. It also replaces one chosen group with a random word that is not in the code set, so the decoder's tolerance and isolation between groups are tested directly. An exhaustive sweep of all 16-bit words covers every pairing of nibbles at every boundary.

// File: rtl/fpf_pkg.sv
package fpf_pkg;

    localparam int GRP_DW     = 4;
    localparam int GRP_CW     = 5;
    localparam int JCT_W      = 3;
    localparam int GRP_STRIDE = GRP_CW + JCT_W;
    localparam int CODE_SPACE = 1 << GRP_CW;

    typedef logic [GRP_DW-1:0] nib_t;
    typedef logic [GRP_CW-1:0] cw_t;

    typedef struct packed {
        logic hit;
        nib_t val;
    } dec_res_t;

    // True when three neighbouring wires hold neither 010 nor 101
    function automatic logic window_ok(input logic [2:0] w);
        return !((w == 3'b010) || (w == 3'b101));
    endfunction

    function automatic logic cw_clean(input cw_t c);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i <= GRP_CW - 3; i++) begin
            if (!window_ok(c[i +: 3])) ok = 1'b0;
        end
        return ok;
    endfunction

    // Rank-ordered code: data k -> k-th clean word in ascending order
    function automatic cw_t enc_nib(input nib_t d);
        int   rank;
        cw_t  res;
        cw_t  cand;
        rank = 0;
        res  = '0;
        for (int v = 0; v < CODE_SPACE; v++) begin
            cand = cw_t'(v);
            if (cw_clean(cand)) begin
                if (rank == int'(d)) res = cand;
                rank++;
            end
        end
        return res;
    endfunction

    function automatic dec_res_t dec_cw(input cw_t c);
        int       rank;
        dec_res_t res;
        cw_t      cand;
        rank = 0;
        res  = '0;
        for (int v = 0; v < CODE_SPACE; v++) begin
            cand = cw_t'(v);
            if (cw_clean(cand)) begin
                if (cand == c) begin
                    res.hit = 1'b1;
                    res.val = nib_t'(rank);
                end
                rank++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/fpf_group_enc.sv
module fpf_group_enc
    import fpf_pkg::*;
(
    input  nib_t nib,
    output cw_t  cw
);
    always_comb cw = enc_nib(nib);
endmodule

// File: rtl/fpf_group_dec.sv
module fpf_group_dec
    import fpf_pkg::*;
(
    input  cw_t  cw,
    output nib_t nib
);
    dec_res_t res;

    always_comb begin
        res = dec_cw(cw);
        nib = res.hit ? res.val : '0;
    end
endmodule

// File: rtl/fpf_junction.sv
module fpf_junction
    import fpf_pkg::*;
(
    input  logic             left_edge,
    input  logic             right_edge,
    output logic [JCT_W-1:0] jw
);
    // Lowest junction wire touches the left group, highest the right group
    always_comb begin
        jw          = {JCT_W{left_edge}};
        jw[JCT_W-1] = right_edge;
    end
endmodule

// File: rtl/fpf_bus_codec.sv
module fpf_bus_codec
    import fpf_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int NGRP   = DATA_W / GRP_DW,
    localparam int BUS_W  = NGRP * GRP_CW + (NGRP - 1) * JCT_W
) (
    input  logic [DATA_W-1:0] enc_data,
    output logic [BUS_W-1:0]  enc_bus,
    input  logic [BUS_W-1:0]  dec_bus,
    output logic [DATA_W-1:0] dec_data
);

    if ((DATA_W % GRP_DW) != 0 || DATA_W < GRP_DW) begin : g_bad_width
        $error("DATA_W must be a positive multiple of 4");
    end

    cw_t enc_cw [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        fpf_group_enc u_enc (
            .nib (enc_data[g*GRP_DW +: GRP_DW]),
            .cw  (enc_cw[g])
        );
        assign enc_bus[g*GRP_STRIDE +: GRP_CW] = enc_cw[g];

        fpf_group_dec u_dec (
            .cw  (dec_bus[g*GRP_STRIDE +: GRP_CW]),
            .nib (dec_data[g*GRP_DW +: GRP_DW])
        );

        if (g < NGRP - 1) begin : g_jct
            logic [JCT_W-1:0] jct_w;
            logic [JCT_W-1:0] rx_jct_unused;

            fpf_junction u_jct (
                .left_edge  (enc_cw[g][GRP_CW-1]),
                .right_edge (enc_cw[g+1][0]),
                .jw         (jct_w)
            );
            assign enc_bus[g*GRP_STRIDE + GRP_CW +: JCT_W] = jct_w;
            assign rx_jct_unused = dec_bus[g*GRP_STRIDE + GRP_CW +: JCT_W];
        end
    end

endmodule

// File: rtl/fpf_bus_codec_chk.sv
module fpf_bus_codec_chk
    import fpf_pkg::*;
#(
    parameter  int DATA_W = 16,
    localparam int NGRP   = DATA_W / GRP_DW,
    localparam int BUS_W  = NGRP * GRP_CW + (NGRP - 1) * JCT_W
) (
    input logic [DATA_W-1:0] enc_data,
    input logic [BUS_W-1:0]  enc_bus,
    input logic [BUS_W-1:0]  dec_bus,
    input logic [DATA_W-1:0] dec_data
);

    always_comb begin
        for (int i = 0; i <= BUS_W - 3; i++) begin
            a_r1_no_forbidden: assert (window_ok(enc_bus[i +: 3]));
        end
        for (int g = 0; g < NGRP; g++) begin
            a_r2_group_is_code: assert (cw_clean(enc_bus[g*GRP_STRIDE +: GRP_CW]));
            if (!cw_clean(dec_bus[g*GRP_STRIDE +: GRP_CW])) begin
                a_r8_bad_group_zero: assert (dec_data[g*GRP_DW +: GRP_DW] == '0);
            end
        end
        for (int g = 0; g < NGRP - 1; g++) begin
            a_r3_junction_edges: assert (
                enc_bus[g*GRP_STRIDE+5] == enc_bus[g*GRP_STRIDE+4] &&
                enc_bus[g*GRP_STRIDE+6] == enc_bus[g*GRP_STRIDE+4] &&
                enc_bus[g*GRP_STRIDE+7] == enc_bus[g*GRP_STRIDE+8]);
        end
        if (dec_bus == enc_bus) begin
            a_r6_roundtrip: assert (dec_data == enc_data);
        end
    end

endmodule

bind fpf_bus_codec fpf_bus_codec_chk #(.DATA_W(DATA_W)) u_chk (
    .enc_data (enc_data),
    .enc_bus  (enc_bus),
    .dec_bus  (dec_bus),
    .dec_data (dec_data)
);

// File: tb/fpf_bus_codec_tb.sv
module fpf_bus_codec_tb;

    localparam int DW  = 16;
    localparam int NG  = DW / 4;
    localparam int BW  = 8 * NG - 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] data_i = '0;
    logic [BW-1:0] bus_o;
    logic [BW-1:0] bus_force = '0;
    logic          loop_en = 1'b1;
    logic [BW-1:0] bus_i;
    logic [DW-1:0] data_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    assign bus_i = loop_en ? bus_o : bus_force;

    fpf_bus_codec #(.DATA_W(DW)) u_dut (
        .enc_data (data_i),
        .enc_bus  (bus_o),
        .dec_bus  (bus_i),
        .dec_data (data_o)
    );

    function automatic bit bad3(input logic [2:0] w);
        return (w[0] == w[2]) && (w[1] != w[0]);
    endfunction

    function automatic bit clean5(input logic [4:0] c);
        for (int i = 0; i < 3; i++) if (bad3(c[i +: 3])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [4:0] ref_cw(input logic [3:0] n);
        int k = 0;
        for (int v = 0; v < 32; v++) begin
            if (clean5(5'(v))) begin
                if (k == int'(n)) return 5'(v);
                k++;
            end
        end
        return 5'h0;
    endfunction

    function automatic logic [BW-1:0] ref_bus(input logic [DW-1:0] d);
        logic [BW-1:0] b = '0;
        logic [4:0]    c;
        logic [4:0]    nx;
        for (int g = 0; g < NG; g++) begin
            c = ref_cw(d[4*g +: 4]);
            b[8*g +: 5] = c;
            if (g < NG - 1) begin
                nx = ref_cw(d[4*g+4 +: 4]);
                b[8*g+5] = c[4];
                b[8*g+6] = c[4];
                b[8*g+7] = nx[0];
            end
        end
        return b;
    endfunction

    function automatic bit bus_clean(input logic [BW-1:0] b);
        for (int i = 0; i <= BW - 3; i++) if (bad3(b[i +: 3])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [DW-1:0] d);
        @(posedge clk);
        data_i = d;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog R1..R8 run actual=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] x;
        logic [BW-1:0] first_bus;
        logic [BW-1:0] b;
        logic [4:0]    bad;
        int            gsel;
        void'($urandom(32'h5eed_c0de));

        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Reset-time value: zero word gives an all-zero bus (R2)
        apply('0);
        check(bus_o == '0, "R2 zero word", 32'(bus_o), 32'h0);
        check(data_o == '0, "R6 zero word", 32'(data_o), 32'h0);

        // R4 width of the coded bus
        check($bits(bus_o) == 29, "R4 bus width", 32'($bits(bus_o)), 32'd29);

        // R2 explicit code points
        apply(16'h0000 | 16'hF);
        check(bus_o[4:0] == 5'h1F, "R2 nibble F", 32'(bus_o[4:0]), 32'h1F);
        apply(16'h0002);
        check(bus_o[4:0] == 5'h03, "R2 nibble 2", 32'(bus_o[4:0]), 32'h03);
        apply(16'h0005);
        check(bus_o[4:0] == 5'h0C, "R2 nibble 5", 32'(bus_o[4:0]), 32'h0C);
        apply(16'hFFFF);
        check(bus_o == '1, "R3 all ones", 32'(bus_o), 32'h1FFFFFFF);

        // Exhaustive sweep: R1, R2/R3 layout, R6 round trip
        for (int v = 0; v < (1 << DW); v++) begin
            apply(DW'(v));
            check(bus_clean(bus_o), "R1 windows", 32'(bus_o), 32'(ref_bus(DW'(v))));
            check(bus_o == ref_bus(DW'(v)), "R2 R3 layout", 32'(bus_o), 32'(ref_bus(DW'(v))));
            check(data_o == DW'(v), "R6 round trip", 32'(data_o), 32'(v));
        end

        // R5 memoryless: same word after unrelated traffic gives same bus
        for (int t = 0; t < 20; t++) begin
            x = DW'($urandom);
            apply(x);
            first_bus = bus_o;
            for (int j = 0; j < 4; j++) apply(DW'($urandom));
            apply(x);
            check(bus_o == first_bus, "R5 memoryless", 32'(bus_o), 32'(first_bus));
        end

        // R7 junction wires ignored by decoder
        loop_en = 1'b0;
        for (int t = 0; t < 200; t++) begin
            x = DW'($urandom);
            b = ref_bus(x);
            for (int g = 0; g < NG - 1; g++) b[8*g+5 +: 3] = 3'($urandom);
            @(posedge clk);
            bus_force = b;
            @(negedge clk);
            check(data_o == x, "R7 junction ignored", 32'(data_o), 32'(x));
        end

        // R8 non-code group decodes to zero, neighbours intact
        for (int t = 0; t < 200; t++) begin
            x = DW'($urandom);
            b = ref_bus(x);
            gsel = int'($urandom % NG);
            bad = 5'($urandom);
            while (clean5(bad)) bad = 5'($urandom);
            b[8*gsel +: 5] = bad;
            x[4*gsel +: 4] = 4'h0;
            @(posedge clk);
            bus_force = b;
            @(negedge clk);
            check(data_o == x, "R8 bad group", 32'(data_o), 32'(x));
        end
        bus_force = ref_bus(16'h0000);
        bus_force[4:0] = 5'b01010;
        @(negedge clk);
        check(data_o == '0, "R8 directed 01010", 32'(data_o), 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule